// File: doc/BRIEF.md
# Debug Halt Control and Status Register

This block is a 32-bit control and status register that an external debugger uses to stop, resume and single-step a processor core. It has one register write/read port. A source flag on that port says whether each access comes from the external debug port or from software running on the core. A write changes the register only when its upper half carries the 16-bit unlock key. The debug enable bit can be changed only by a write from the debug port. The halt, step and interrupt-mask bits reach the core only while debug is enabled.

Behind the register sits a small run/halt/step controller. It drives a halt request, a single-step mode line and an interrupt-mask line to the core. When stepping is on and the debugger asks the core to resume, the controller releases the halt request for exactly one retired instruction and then asserts it again. It stays asserted until the next resume request. The register reports the core's halted, sleeping, locked-up and register-ready states live. It also holds two sticky flags, one for instruction retired and one for reset occurred, which clear when the register is read.

Top module: `dbg_halt_ctl`

## Requirements
- R1: After reset, rdata equals 0x02000000 (only the sticky reset flag, bit 25, is set) while all status inputs are low, and halt_req, step_mode and irq_mask are 0.
- R2: A write whose bits [31:16] differ from 0xA05F leaves the control bits [3:0] unchanged.
- R3: Control bit 0 (debug enable) takes the value of wdata[0] only on a keyed write with from_dbg=1. A keyed write with from_dbg=0 leaves bit 0 unchanged.
- R4: While bit 0 reads 0, halt_req, step_mode and irq_mask are all 0, whatever bits 1 to 3 hold.
- R5: A keyed write stores wdata[1] into control bit 1 (halt). While debug is enabled, halt_req equals bit 1 from the cycle after the write: 1 requests a halt and 0 requests a resume.
- R6: Control bits 2 (step) and 3 (mask interrupts) take wdata[2] and wdata[3] on a keyed write. The exception is when debug enable reads 1 and core_halted is 0: then both bits keep their values. While enabled, step_mode equals bit 2 and irq_mask equals bit 3.
- R7: Bits 16, 17, 18 and 19 show core_regrdy, core_halted, core_sleeping and core_lockup live. Bit 17 is 0 whenever core_halted is 0. Bits [15:4], [23:20] and [31:26] read as 0.
- R8: Bit 24 is set by a core_retire pulse and bit 25 by a core_reset_evt pulse. Each stays set until a cycle with rd_en=1, after which it reads 0, unless its pulse arrives in that same cycle, in which case it stays set.
- R9: When a keyed write leaves debug enabled, step=1 and halt=0, halt_req stays low until the first core_retire pulse. From the next cycle bit 1 reads 1 and halt_req is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears sticky flags) |
| from_dbg | input | 1 | 1 = access comes from the debug port, 0 = from core software |
| wdata | input | 32 | Write data including key in [31:16] |
| rdata | output | 32 | Current register value |
| core_halted | input | 1 | Core is halted |
| core_sleeping | input | 1 | Core is sleeping |
| core_lockup | input | 1 | Core is locked up |
| core_regrdy | input | 1 | Core register transfer complete |
| core_retire | input | 1 | One-cycle pulse per retired instruction |
| core_reset_evt | input | 1 | One-cycle pulse when the core was reset |
| halt_req | output | 1 | Halt request to core |
| step_mode | output | 1 | Single-step mode to core |
| irq_mask | output | 1 | Interrupt mask to core |

## Verification
The assertions assume that core_retire and core_reset_evt are single-cycle pulses. They also assume that core_halted changes only between writes, never in the same cycle as one. The stimulus holds every status input steady around each write and raises the pulses for one cycle at a time. The step-completion property further assumes that no write coincides with the retire pulse that ends a step, and the bench never issues both in the same cycle.

// File: rtl/dhc_pkg.sv
package dhc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned KEY_W  = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F;
  localparam int unsigned CTL_W  = 4;
  localparam int unsigned STAT_W = 4;
  localparam int unsigned STICKY_N = 2;
  localparam int unsigned STAT_LSB = 16;
  localparam int unsigned STICKY_LSB = 24;

  typedef struct packed {
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctl_t;

  function automatic logic key_match(input logic [DATA_W-1:0] d);
    return d[DATA_W-1 -: KEY_W] == UNLOCK_KEY;
  endfunction

  function automatic logic [DATA_W-1:0] pack_view(
    input ctl_t c, input logic [STAT_W-1:0] st, input logic [STICKY_N-1:0] sk);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CTL_W-1:0] = c;
    v[STAT_LSB +: STAT_W] = st;
    v[STICKY_LSB +: STICKY_N] = sk;
    return v;
  endfunction
endpackage

// File: rtl/dhc_key_gate.sv
module dhc_key_gate
  import dhc_pkg::*;
(
  input  logic              wr_en,
  input  logic              from_dbg,
  input  logic [DATA_W-1:0] wdata,
  output logic              acc,
  output logic              acc_dbg
);
  always_comb begin
    acc     = wr_en & key_match(wdata);
    acc_dbg = acc & from_dbg;
  end
endmodule

// File: rtl/dhc_ctrl_regs.sv
module dhc_ctrl_regs
  import dhc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             acc_dbg,
  input  logic [CTL_W-1:0] wnib,
  input  logic             core_halted,
  input  logic             core_retire,
  output ctl_t             ctl,
  output logic             step_start,
  output logic             step_done
);
  ctl_t q, nxt;
  logic step_run, step_run_nxt;
  logic frozen;

  always_comb begin
    frozen = q.en & ~core_halted;
    nxt = q;
    step_done = step_run & core_retire & ~acc;
    if (acc) begin
      if (acc_dbg) nxt.en = wnib[0];
      nxt.halt = wnib[1];
      if (!frozen) begin
        nxt.step = wnib[2];
        nxt.mask = wnib[3];
      end
    end else if (step_done) begin
      nxt.halt = 1'b1;
    end
    step_start = acc & nxt.en & nxt.step & ~nxt.halt;
    if (acc) step_run_nxt = step_start;
    else if (step_done) step_run_nxt = 1'b0;
    else step_run_nxt = step_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
      step_run <= 1'b0;
    end else begin
      q <= nxt;
      step_run <= step_run_nxt;
    end
  end

  assign ctl = q;
endmodule

// File: rtl/dhc_sticky.sv
module dhc_sticky #(
  parameter int unsigned N = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         rd_clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f <= RST_VAL[i];
      else if (set_vec[i]) f <= 1'b1;
      else if (rd_clr) f <= 1'b0;
    end
    assign flags[i] = f;
  end
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
  import dhc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              from_dbg,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              core_halted,
  input  logic              core_sleeping,
  input  logic              core_lockup,
  input  logic              core_regrdy,
  input  logic              core_retire,
  input  logic              core_reset_evt,
  output logic              halt_req,
  output logic              step_mode,
  output logic              irq_mask
);
  logic acc, acc_dbg, step_start, step_done;
  ctl_t ctl;
  logic [STICKY_N-1:0] sticky;
  logic [STAT_W-1:0] live;

  dhc_key_gate u_gate (
    .wr_en(wr_en), .from_dbg(from_dbg), .wdata(wdata),
    .acc(acc), .acc_dbg(acc_dbg)
  );

  dhc_ctrl_regs u_ctl (
    .clk(clk), .rst_n(rst_n), .acc(acc), .acc_dbg(acc_dbg),
    .wnib(wdata[CTL_W-1:0]), .core_halted(core_halted),
    .core_retire(core_retire), .ctl(ctl),
    .step_start(step_start), .step_done(step_done)
  );

  dhc_sticky #(.N(STICKY_N), .RST_VAL(2'b10)) u_sticky (
    .clk(clk), .rst_n(rst_n),
    .set_vec({core_reset_evt, core_retire}),
    .rd_clr(rd_en), .flags(sticky)
  );

  assign live = {core_lockup, core_sleeping, core_halted, core_regrdy};
  assign rdata = pack_view(ctl, live, sticky);
  assign halt_req  = ctl.en & ctl.halt;
  assign step_mode = ctl.en & ctl.step;
  assign irq_mask  = ctl.en & ctl.mask;
endmodule

// File: rtl/dhc_checker.sv
module dhc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        from_dbg,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        core_halted,
  input logic        core_retire,
  input logic        halt_req,
  input logic        step_mode,
  input logic        irq_mask,
  input logic        step_done
);
  a_r2_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[31:16] != 16'hA05F && !core_retire) |=> $stable(rdata[3:0]));
  a_r3_sw_no_en: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !from_dbg) |=> $stable(rdata[0]));
  a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[0] |-> (!halt_req && !step_mode && !irq_mask));
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rdata[0] && !core_halted) |=> $stable(rdata[3:2]));
  a_r7_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[15:4] == 12'h0 && rdata[23:20] == 4'h0 && rdata[31:26] == 6'h0);
  a_r8_retire_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    core_retire |=> rdata[24]);
  a_r9_step_rehalt: assert property (@(posedge clk) disable iff (!rst_n)
    (core_retire && !wr_en && step_mode && !halt_req) |=> halt_req);
  a_r9_done_event: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> rdata[1]);
endmodule

bind dbg_halt_ctl dhc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .from_dbg(from_dbg),
  .wdata(wdata), .rdata(rdata), .core_halted(core_halted),
  .core_retire(core_retire), .halt_req(halt_req),
  .step_mode(step_mode), .irq_mask(irq_mask), .step_done(step_done)
);

// File: tb/tb_dbg_halt_ctl.sv
module tb_dbg_halt_ctl;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, from_dbg = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic core_halted = 0, core_sleeping = 0, core_lockup = 0, core_regrdy = 0;
  logic core_retire = 0, core_reset_evt = 0;
  logic halt_req, step_mode, irq_mask;
  int checks = 0, errors = 0;
  logic m_en = 0, m_h = 0, m_s = 0, m_m = 0;

  always #10 clk = ~clk;

  dbg_halt_ctl dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] key, input logic [3:0] nib, input logic src);
    @(negedge clk);
    wr_en = 1; from_dbg = src; wdata = {key, 12'h0, nib};
    @(negedge clk);
    wr_en = 0; wdata = 0;
  endtask

  task automatic check_ctl(input string req);
    chk(req, {28'h0, rdata[3:0]}, {28'h0, m_m, m_s, m_h, m_en});
    chk(req, {29'h0, halt_req, step_mode, irq_mask},
        {29'h0, m_en & m_h, m_en & m_s, m_en & m_m});
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expected=done actual=timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", rdata, 32'h0200_0000);
    chk("R1", {29'h0, halt_req, step_mode, irq_mask}, 32'h0);

    // R2 R3 R4 R5 R6: sweep key, source, core state, control nibble
    for (int k = 0; k < 2; k++)
      for (int src = 0; src < 2; src++)
        for (int hl = 0; hl < 2; hl++)
          for (int n = 0; n < 16; n++) begin
            logic [3:0] nb;
            logic frz;
            nb = n[3:0];
            @(negedge clk);
            core_halted = hl[0];
            frz = m_en & ~core_halted;
            wr(k == 0 ? 16'hA05F : 16'hA05E, nb, src[0]);
            if (k == 0) begin
              if (src == 1) m_en = nb[0];
              m_h = nb[1];
              if (!frz) begin m_s = nb[2]; m_m = nb[3]; end
            end
            if (k != 0) check_ctl("R2");
            else if (src == 0) check_ctl("R3");
            else if (frz) check_ctl("R6");
            else check_ctl("R5");
            if (!m_en) chk("R4", {29'h0, halt_req, step_mode, irq_mask}, 32'h0);
          end

    // R7 live status and zero fields
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      {core_lockup, core_sleeping, core_halted, core_regrdy} = s[3:0];
      #1;
      chk("R7", {12'h0, rdata[19:16]}, {12'h0, s[3:0]});
      chk("R7", {rdata[31:26], rdata[23:20], rdata[15:4]}, 32'h0);
    end
    @(negedge clk);
    {core_lockup, core_sleeping, core_halted, core_regrdy} = 4'b0010;

    // R8 sticky flags
    @(negedge clk); rd_en = 1; @(negedge clk); rd_en = 0;
    chk("R8", {30'h0, rdata[25:24]}, 32'h0);
    core_retire = 1; @(negedge clk); core_retire = 0;
    chk("R8", {30'h0, rdata[25:24]}, 32'h1);
    core_reset_evt = 1; rd_en = 1; @(negedge clk);
    core_reset_evt = 0; rd_en = 0;
    chk("R8", {30'h0, rdata[25:24]}, 32'h2);
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk("R8", {30'h0, rdata[25:24]}, 32'h0);

    // R9 single step
    core_halted = 1;
    wr(16'hA05F, 4'b0111, 1'b1);
    chk("R9", {31'h0, halt_req}, 32'h1);
    wr(16'hA05F, 4'b0101, 1'b1);
    chk("R9", {31'h0, halt_req}, 32'h0);
    core_halted = 0;
    repeat (3) @(negedge clk);
    chk("R9", {31'h0, halt_req}, 32'h0);
    core_retire = 1; @(negedge clk); core_retire = 0;
    chk("R9", {30'h0, rdata[1], halt_req}, 32'h3);
    core_halted = 1;
    wr(16'hA05F, 4'b0101, 1'b1);
    chk("R9", {31'h0, halt_req}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule